// File: doc/BRIEF.md
# I2C Bus Tick Generator with Two-Factor Divider

This block derives the timing strobes that a byte-level I2C engine needs from the system clock. A small clock register holds two factors: a linear factor M and an exponent N. A prescaler divides the system clock by (M+1) times a power of two set by N, and emits a one-cycle oversample tick. A modulo-10 phase counter advances on that tick, so one SCL period always spans ten oversample ticks. On these ticks the counter marks the half-period boundaries, the centre of each half, and a level that tells which half of the SCL period is running.

A strap input selects between two exponent conventions. In the default convention the power of two is 2^(N+1). In the alternate convention it is 2^N. The resulting SCL rate is therefore f_clk / (10·(M+1)·2^(N+1)) or f_clk / (10·(M+1)·2^N). Software picks M and N for the wanted rate. The reset value of the register is a parameter; the default M=15, N=2 gives about 97.7 kHz from a 125 MHz clock, the nearest rate not above 100 kHz. Writing the register, or dropping the engine enable, restarts both counters, so no shortened first period ever appears.

Top module: `i2c_baud_gen`

## Requirements
- R1: After a synchronous active-low reset, all four outputs are low and the register holds the parameter defaults (M=15, N=2). With enable high, the first oversample tick follows 128 cycles after the last reset edge.
- R2: The exponent N is taken from register bits 2:0 and the linear factor M from bits 6:3. Bit 7 has no effect.
- R3: With the strap low, the oversample tick repeats every (M+1)·2^(N+1) clock cycles.
- R4: With the strap high, the oversample tick repeats every (M+1)·2^N clock cycles. With M=0 and N=0 it is high on every cycle.
- R5: When the division is above 1, each oversample tick is high for exactly one cycle.
- R6: The half tick coincides with every fifth oversample tick: the first tick after a restart, then the sixth, and so on. The half ticks are therefore 5 tick periods apart.
- R7: The mid tick coincides with the oversample tick two ticks after each half tick. It never coincides with a half tick.
- R8: The SCL phase level goes low at the half tick that opens an SCL period and high at the half tick five ticks later. It is low after any restart, and an SCL period is ten tick periods.
- R9: A register write restarts both counters. The first tick after the write appears exactly one division period after the clock edge that took the write.
- R10: While the engine enable is low, no tick is produced, the phase level is low and both counters stay cleared. The first tick after enable returns appears one division period after the last edge with enable low.
- R11: If the strap changes during a period and the prescaler count is already at or past the new terminal value, the period ends on the next edge. Otherwise the period ends at the new terminal value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Clock register write strobe |
| cfg_wdata | input | 8 | Register write data: N in bits 2:0, M in bits 6:3 |
| exp_alt | input | 1 | Exponent convention strap: 0 uses 2^(N+1), 1 uses 2^N |
| eng_en | input | 1 | Engine enable; low holds all ticks off |
| os_tick | output | 1 | Oversample tick, ten per SCL period |
| half_tick | output | 1 | SCL half-period boundary tick |
| mid_tick | output | 1 | Tick at the centre of each SCL half |
| scl_phase | output | 1 | 0 in the first half of the SCL period, 1 in the second |

## Verification
All outputs are registered, so a decision taken at one clock edge is visible in the cycle that follows it. The first tick after a restart is due exactly one division period of edges after the edge that took the write, the enable drop or the reset. The bench drives inputs on the falling edge and steps a behavioural model on each rising edge. It compares all four outputs on the next falling edge, where that edge's result has settled. The directed period checks count rising edges from the restart edge, or from a tick, up to the falling edge on which the next tick is first seen. They compare that count with the division computed from M, N and the strap.

// File: rtl/i2c_baud_pkg.sv
// Package: shared field widths, configuration type and the divider
// terminal-count function for the I2C bus tick generator.
package i2c_baud_pkg;

    // Width of the exponent field N (register bits N_W-1:0)
    localparam int N_W     = 3;
    // Width of the linear field M (register bits N_W+M_W-1:N_W)
    localparam int M_W     = 4;
    // Oversample ticks per SCL period
    localparam int SCL_SUB = 10;
    // Prescaler counter width: largest division is 2^M_W * 2^(2^N_W)
    localparam int CNT_W   = M_W + (1 << N_W);
    // Phase counter width
    localparam int PH_W    = $clog2(SCL_SUB);

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } baud_cfg_t;

    // Terminal count (division minus one) for a configuration and strap
    function automatic logic [CNT_W-1:0] term_of(baud_cfg_t c, logic alt);
        logic [CNT_W:0] div;
        logic [N_W:0]   sh;
        sh  = {1'b0, c.n} + {{N_W{1'b0}}, ~alt};
        div = ((CNT_W+1)'(c.m) + (CNT_W+1)'(1)) << sh;
        return CNT_W'(div - (CNT_W+1)'(1));
    endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
// Clock register: holds the M and N factors.
// Assumes: the write data layout puts N in the low bits and M directly
// above it; bits above M are ignored. Reset loads parameter defaults.
module baud_cfg_reg
    import i2c_baud_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int RST_M = 15,
    parameter int RST_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output baud_cfg_t        cfg
);

    localparam int N_LSB = 0;
    localparam int M_LSB = N_LSB + N_W;

    // Field capture on write, defaults on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.m <= M_W'(RST_M);
            cfg.n <= N_W'(RST_N);
        end else if (wr_en) begin
            cfg.m <= wr_data[M_LSB +: M_W];
            cfg.n <= wr_data[N_LSB +: N_W];
        end
    end

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));

endmodule

// File: rtl/baud_prescaler.sv
// Prescaler: counts system clocks up to the terminal value and produces
// a combinational step strobe plus the registered oversample tick.
// Assumes: restart has priority; a terminal value lowered below the
// current count ends the period on the next edge (>= compare).
module baud_prescaler
    import i2c_baud_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] term,
    output logic         step,
    output logic         os_tick
);

    logic [W-1:0] pre_cnt;
    logic         at_end;

    // Terminal detect, tolerant of a terminal that moved below the count
    always_comb begin
        at_end = (pre_cnt >= term);
        step   = at_end && !restart;
    end

    // Division counter with restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_cnt <= '0;
        end else if (at_end) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + W'(1);
        end
    end

    // Registered oversample tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            os_tick <= 1'b0;
        end else begin
            os_tick <= step;
        end
    end

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && term != '0) |=> !os_tick);

    // R9
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !os_tick);

    // R3
    tick_starts_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> pre_cnt == '0);

endmodule

// File: rtl/baud_phase.sv
// Phase counter: modulo-SCL_SUB count of oversample steps. Marks the two
// half-period boundaries, the centre of each half, and the SCL half level.
// Assumes: step is a single-cycle strobe from the prescaler; outputs are
// registered on the same edge as the oversample tick.
module baud_phase
    import i2c_baud_pkg::*;
#(
    parameter int SUB = SCL_SUB,
    parameter int PW  = PH_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    output logic half_tick,
    output logic mid_tick,
    output logic scl_phase
);

    localparam int HALF = SUB / 2;
    localparam int MID  = HALF / 2;

    logic [PW-1:0] ph_cnt;
    logic [1:0]    at_half;
    logic [1:0]    at_mid;

    // Match decoders, one per SCL half
    for (genvar h = 0; h < 2; h++) begin : g_half
        always_comb begin
            at_half[h] = (ph_cnt == PW'(h * HALF));
            at_mid[h]  = (ph_cnt == PW'(h * HALF + MID));
        end
    end

    // Modulo-SUB step counter
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ph_cnt <= '0;
        end else if (step) begin
            ph_cnt <= (ph_cnt == PW'(SUB - 1)) ? '0 : ph_cnt + PW'(1);
        end
    end

    // Boundary and centre strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_tick <= 1'b0;
            mid_tick  <= 1'b0;
        end else begin
            half_tick <= step && (|at_half);
            mid_tick  <= step && (|at_mid);
        end
    end

    // SCL half level: low in the first half, high in the second
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            scl_phase <= 1'b0;
        end else if (step && at_half[0]) begin
            scl_phase <= 1'b0;
        end else if (step && at_half[1]) begin
            scl_phase <= 1'b1;
        end
    end

    // R8
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_cnt < PW'(SUB));

    // R8
    phase_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_phase) |-> half_tick);

    // R7
    mid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_tick |=> !mid_tick);

endmodule

// File: rtl/i2c_baud_gen.sv
// Top: I2C bus tick generator. Clock register, prescaler and phase
// counter. A register write or a low engine enable restarts both counters.
// Assumes: exp_alt is a quasi-static strap; cfg_wdata is meaningful only
// while cfg_we is high.
module i2c_baud_gen
    import i2c_baud_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int RST_M = 15,
    parameter int RST_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             exp_alt,
    input  logic             eng_en,
    output logic             os_tick,
    output logic             half_tick,
    output logic             mid_tick,
    output logic             scl_phase
);

    baud_cfg_t        cfg;
    logic [CNT_W-1:0] term;
    logic             restart;
    logic             step;

    // Restart source and terminal value
    always_comb begin
        restart = cfg_we || !eng_en;
        term    = term_of(cfg, exp_alt);
    end

    baud_cfg_reg #(
        .REG_W (REG_W),
        .RST_M (RST_M),
        .RST_N (RST_N)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg     (cfg)
    );

    baud_prescaler #(
        .W (CNT_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .term    (term),
        .step    (step),
        .os_tick (os_tick)
    );

    baud_phase #(
        .SUB (SCL_SUB),
        .PW  (PH_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .step      (step),
        .half_tick (half_tick),
        .mid_tick  (mid_tick),
        .scl_phase (scl_phase)
    );

    // R6
    half_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |-> os_tick);

    // R7
    mid_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_tick |-> (os_tick && !half_tick));

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_en |=> (!os_tick && !half_tick && !mid_tick && !scl_phase));

endmodule

// File: tb/i2c_baud_gen_test.sv
// Bench: behavioural reference stepped on every rising edge and compared
// on every falling edge, plus directed period measurements.
module i2c_baud_gen_test;

    localparam int RST_M = 15;
    localparam int RST_N = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       exp_alt = 1'b0;
    logic       eng_en = 1'b1;
    logic       os_tick, half_tick, mid_tick, scl_phase;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    i2c_baud_gen #(.REG_W(8), .RST_M(RST_M), .RST_N(RST_N)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .exp_alt(exp_alt), .eng_en(eng_en), .os_tick(os_tick),
        .half_tick(half_tick), .mid_tick(mid_tick), .scl_phase(scl_phase)
    );

    // Reference model state
    int  mm, mn, pre, ph, div;
    bit  e_os, e_half, e_mid, e_phase, wrap, live = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Model step on each rising edge, using inputs driven at the falling edge
    always @(posedge clk) begin
        cyc++;
        live = 1;
        if (!rst_n) begin
            mm = RST_M; mn = RST_N; pre = 0; ph = 0;
            e_os = 0; e_half = 0; e_mid = 0; e_phase = 0;
        end else if (cfg_we || !eng_en) begin
            if (cfg_we) begin
                mm = int'(cfg_wdata[6:3]);
                mn = int'(cfg_wdata[2:0]);
            end
            pre = 0; ph = 0;
            e_os = 0; e_half = 0; e_mid = 0; e_phase = 0;
        end else begin
            div    = (mm + 1) * (1 << (exp_alt ? mn : mn + 1));
            wrap   = (pre >= div - 1);
            e_os   = wrap;
            e_half = wrap && (ph == 0 || ph == 5);
            e_mid  = wrap && (ph == 2 || ph == 7);
            if (wrap && ph == 0) e_phase = 0;
            if (wrap && ph == 5) e_phase = 1;
            pre = wrap ? 0 : pre + 1;
            if (wrap) ph = (ph + 1) % 10;
        end
    end

    // Compare every output on each falling edge
    always @(negedge clk) begin
        if (live && !done) begin
            check(os_tick == e_os, "R3 os_tick", int'(os_tick), int'(e_os));
            check(half_tick == e_half, "R6 half_tick", int'(half_tick), int'(e_half));
            check(mid_tick == e_mid, "R7 mid_tick", int'(mid_tick), int'(e_mid));
            check(scl_phase == e_phase, "R8 scl_phase", int'(scl_phase), int'(e_phase));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Edges from now until os_tick is seen high on a falling edge
    task automatic wait_sig(input int which, output int n);
        bit seen;
        n = 0;
        seen = 0;
        while (!seen && n < 20000) begin
            @(negedge clk);
            n++;
            case (which)
                0: seen = os_tick;
                1: seen = half_tick;
                2: seen = mid_tick;
                3: seen = scl_phase;
                default: seen = !scl_phase;
            endcase
        end
    endtask

    task automatic wr(input logic [7:0] d);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = 8'h00;
    endtask

    int n;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!os_tick && !half_tick && !mid_tick && !scl_phase, "R1 reset outputs",
              int'({os_tick, half_tick, mid_tick, scl_phase}), 0);
        rst_n = 1'b1;
        wait_sig(0, n); check(n == 128, "R1 default first tick", n, 128);
        @(negedge clk); check(!os_tick, "R5 single-cycle tick", int'(os_tick), 0);
        wait_sig(0, n); check(n == 127, "R3 default period", n + 1, 128);

        // R9 and R3: M=1, N=0 gives 4
        wr(8'b0000_1000);
        wait_sig(0, n); check(n == 4, "R9 first tick after write", n, 4);
        wait_sig(0, n); check(n == 4, "R3 period M=1 N=0", n, 4);
        // R6: half ticks 5 periods apart
        wait_sig(1, n);
        wait_sig(1, n); check(n == 20, "R6 half spacing", n, 20);
        // R7: mid two ticks after half
        wait_sig(2, n); check(n == 8, "R7 mid after half", n, 8);
        // R8: high half lasts five tick periods
        wait_sig(3, n);
        wait_sig(4, n); check(n == 20, "R8 high half length", n, 20);
        wait_sig(3, n); check(n == 20, "R8 low half length", n, 20);

        // R2: 0x8B -> N=3, M=1, bit 7 ignored -> 2*16 = 32
        wr(8'h8B);
        wait_sig(0, n); check(n == 32, "R2 field decode", n, 32);
        wr(8'h0B);
        wait_sig(0, n); check(n == 32, "R2 bit 7 ignored", n, 32);

        // R3: largest division 16*256
        wr(8'h7F);
        wait_sig(0, n); check(n == 4096, "R3 max division", n, 4096);

        // R4: strap high
        exp_alt = 1'b1;
        wr(8'h7F);
        wait_sig(0, n); check(n == 2048, "R4 alt max division", n, 2048);
        wr(8'b0000_1000);
        wait_sig(0, n); check(n == 2, "R4 alt M=1 N=0", n, 2);
        wr(8'h00);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(os_tick, "R4 division of one", int'(os_tick), 1);
        end

        // R11: M=3 N=2, strap low -> 32; switch at count 20 -> terminal 15
        exp_alt = 1'b0;
        wr(8'b0001_1010);
        wait_sig(0, n); check(n == 32, "R11 period before switch", n, 32);
        repeat (20) @(negedge clk);
        exp_alt = 1'b1;
        wait_sig(0, n); check(n == 1, "R11 early end on strap change", n, 1);
        wait_sig(0, n); check(n == 16, "R4 period after switch", n, 16);

        // R10: enable low holds everything off
        eng_en = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            check(!os_tick && !scl_phase, "R10 disabled outputs",
                  int'({os_tick, scl_phase}), 0);
        end
        eng_en = 1'b1;
        wait_sig(0, n); check(n == 16, "R10 first tick after enable", n, 16);

        repeat (5) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule